// File: doc/BRIEF.md
# Three-Wire Serial Control Slave

This block is the control-port slave of a larger chip. A microcontroller reaches it over three lines: a serial clock, a mode line and a shared data line. Every transfer starts with an address phase, in which the mode line is low and eight clock pulses carry one byte. That byte names a target device and a transfer type. A data phase follows, framed by the mode line being high. In it the controller either writes a 16-bit word into one of the slave's registers, marks a register for a later read, or clocks out a reply that holds the register address, a validity flag and the register contents.

The three lines are brought onto the chip's system clock through two-stage synchronizers, and all protocol decisions are made on detected edges of the synchronized serial clock. After reset the slave stays deaf until it has seen one serial clock pulse, and that pulse is used only to wake it. The register file holds up to 128 words of 16 bits. Its size and the device address are parameters.

Top module: `tws_ctrl_slave`

## Requirements
- R1: Every byte and word on the data line, in both directions, is carried least significant bit first. A data word is 16 bits, low byte first.
- R2: After reset the slave accepts nothing and never drives the data line until one rising edge of the serial clock has been seen. That first rising edge is consumed and carries no bit. This happens only once per reset.
- R3: The address phase is the time the mode line is low. The slave is selected only when exactly 8 rising serial clock edges occur in it and bits 7..2 of the received byte equal the parameter DEV_ADDR. Seven pulses or fewer, or a ninth pulse, leave the slave deselected.
- R4: Bits 1..0 of the address byte give the transfer type: 2'b10 is write or pre-read, 2'b11 is read. 2'b00 and 2'b01 select nothing: no register changes and the data line is not driven.
- R5: In a write/pre-read data phase, the first byte is the register byte. If its bit 0 (sent first) is 0, bits 7..1 are a register address and the next 16 bits are written to that register. The write takes effect only when all 16 bits have arrived. A data phase cut short by the mode line falling writes nothing.
- R6: If bit 0 of the register byte is 1, bits 7..1 are latched as the address for later reads, and the rest of that data phase is ignored. The latched address holds over any number of reads.
- R7: In a read data phase, the enable output rises when the mode line goes high and the slave drives 24 bits. Bit 0 is the validity flag (0 = valid), bits 1..7 echo the latched register address, and bits 8..23 are the register word. Each falling serial clock edge moves to the next bit. The enable drops after the 24th falling edge or when the mode line goes low. The output value does not change at any other time while driven.
- R8: The reply is invalid (flag 1, data bits all zero) when no pre-read has occurred since reset, or when the latched address is not below NUM_REGS. Writes to addresses not below NUM_REGS are dropped. Registers read as zero after reset.
- R9: After an address byte whose device field does not match, the enable stays low and no register or latched address changes until the next address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must be several times faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock from the controller |
| ser_mode_i | input | 1 | Mode line: low = address phase, high = data phase |
| ser_dat_i | input | 1 | Data line as seen at the pad input |
| ser_dat_o | output | 1 | Reply bit to drive onto the data line (0 when not driving) |
| ser_dat_oe_o | output | 1 | Data line output enable, high only during a read reply |

## Verification
Each pin change passes through two synchronizer flops and an edge-detect flop, so the enable and reply bit respond three system clocks after the system edge that first samples the change. A committed write shows up in the register file one clock after the 24th data-phase rising edge is detected, and it becomes visible at the ports only through a later pre-read and read. The bench keeps a cycle-accurate model fed with the pin values it samples. It uses that same three-clock delay and compares enable and reply bit at every falling system clock edge. The bus model holds each serial half period for six system clocks and reads the reply bit at the end of each low phase, well after the three-clock delay. Reply contents are also checked against values computed from the requirements.

// File: rtl/tws_pkg.sv
package tws_pkg;

    // serial framing
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned DEV_AW    = 6;
    localparam int unsigned REG_AW    = 7;
    localparam int unsigned WORD_W    = 16;
    localparam int unsigned REPLY_W   = BYTE_W + WORD_W;

    // positions of the three lines inside the synchronizer vector
    localparam int unsigned LINE_N    = 3;
    localparam int unsigned LINE_DAT  = 0;
    localparam int unsigned LINE_MODE = 1;
    localparam int unsigned LINE_CLK  = 2;

    // transfer type carried in the two low bits of the address byte
    typedef enum logic [1:0] {
        XFER_RSV0  = 2'b00,
        XFER_RSV1  = 2'b01,
        XFER_WRITE = 2'b10,
        XFER_READ  = 2'b11
    } xfer_e;

endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lines_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    logic [WIDTH-1:0] stg_q [STAGES];
    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] prev_d;

    // chain of flops per line; stage 0 takes the pads
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            assign stg_d[s] = lines_i;
        end else begin : g_next
            assign stg_d[s] = stg_q[s-1];
        end
    end

    assign prev_d = stg_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
            prev_q <= '0;
        end else begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= stg_d[s];
            prev_q <= prev_d;
        end
    end

    assign lvl_o  = stg_q[STAGES-1];
    assign rise_o = stg_q[STAGES-1] & ~prev_q;
    assign fall_o = ~stg_q[STAGES-1] & prev_q;

endmodule

// File: rtl/tws_regfile.sv
module tws_regfile #(
    parameter int unsigned NUM_REGS = 128,
    parameter int unsigned AW       = 7,
    parameter int unsigned DW       = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o,
    output logic          rvalid_o
);

    logic [DW-1:0] mem_q [NUM_REGS];
    logic          wr_in_range;

    assign wr_in_range = 32'(waddr_i) < NUM_REGS;
    assign rvalid_o    = 32'(raddr_i) < NUM_REGS;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (we_i && wr_in_range && (waddr_i == AW'(i))) mem_q[i] <= wdata_i;
            end
        end
    end

    // out-of-range reads return zero
    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (raddr_i == AW'(i)) rdata_o = mem_q[i];
        end
    end

endmodule

// File: rtl/tws_engine.sv
module tws_engine
    import tws_pkg::*;
#(
    parameter logic [DEV_AW-1:0] DEV_ADDR = 6'h2D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_rise_i,
    input  logic              clk_fall_i,
    input  logic              mode_lvl_i,
    input  logic              mode_rise_i,
    input  logic              mode_fall_i,
    input  logic              dat_i,
    input  logic [WORD_W-1:0] rd_data_i,
    input  logic              rd_inrange_i,
    output logic [REG_AW-1:0] rd_addr_o,
    output logic              wr_en_o,
    output logic [REG_AW-1:0] wr_addr_o,
    output logic [WORD_W-1:0] wr_data_o,
    output logic              oe_o,
    output logic              dout_o,
    output logic              awake_o,
    output logic              sel_o,
    output logic              rd_o
);

    localparam int unsigned ACNT_W = $clog2(BYTE_W + 2);
    localparam int unsigned DCNT_W = $clog2(REPLY_W + 1);
    localparam int unsigned RCNT_W = $clog2(REPLY_W + 1);

    typedef struct packed {
        logic              awake;
        logic [ACNT_W-1:0] acnt;
        logic [BYTE_W-1:0] abyte;
        logic              sel;
        logic              rd;
        logic [DCNT_W-1:0] dcnt;
        logic [BYTE_W-1:0] rbyte;
        logic [WORD_W-1:0] wdata;
        logic [REG_AW-1:0] pre_addr;
        logic              pre_valid;
        logic [REPLY_W-1:0] reply;
        logic [RCNT_W-1:0] rcnt;
        logic              oe;
    } eng_t;

    eng_t q, d;

    logic [BYTE_W-1:0] shift_a;
    logic [BYTE_W-1:0] shift_r;
    logic [WORD_W-1:0] shift_w;
    logic              reply_bad;
    logic [DEV_AW-1:0] dev_fld;
    xfer_e             type_fld;

    always_comb begin
        d        = q;
        wr_en_o  = 1'b0;
        shift_a  = {dat_i, q.abyte[BYTE_W-1:1]};
        shift_r  = {dat_i, q.rbyte[BYTE_W-1:1]};
        shift_w  = {dat_i, q.wdata[WORD_W-1:1]};
        dev_fld  = shift_a[BYTE_W-1:2];
        type_fld = xfer_e'(shift_a[1:0]);
        reply_bad = !q.pre_valid || !rd_inrange_i;

        if (!q.awake) begin
            // first serial clock pulse only wakes the port
            if (clk_rise_i) d.awake = 1'b1;
        end else if (mode_fall_i) begin
            // new address phase: drop any selection and stop driving
            d.acnt = '0;
            d.sel  = 1'b0;
            d.rd   = 1'b0;
            d.oe   = 1'b0;
        end else if (mode_rise_i) begin
            // data phase opens: snapshot the reply for a read
            d.dcnt  = '0;
            d.rcnt  = '0;
            d.oe    = q.sel && q.rd;
            d.reply = {reply_bad ? {WORD_W{1'b0}} : rd_data_i, q.pre_addr, reply_bad};
        end else if (!mode_lvl_i) begin
            if (clk_rise_i) begin
                if (q.acnt < ACNT_W'(BYTE_W)) begin
                    d.abyte = shift_a;
                    d.acnt  = q.acnt + 1'b1;
                    if (q.acnt == ACNT_W'(BYTE_W - 1)) begin
                        d.sel = (dev_fld == DEV_ADDR) &&
                                ((type_fld == XFER_WRITE) || (type_fld == XFER_READ));
                        d.rd  = (type_fld == XFER_READ);
                    end
                end else begin
                    // pulse beyond the eighth: frame is malformed
                    d.sel = 1'b0;
                end
            end
        end else begin
            if (q.sel && !q.rd && clk_rise_i && (q.dcnt < DCNT_W'(REPLY_W))) begin
                d.dcnt = q.dcnt + 1'b1;
                if (q.dcnt < DCNT_W'(BYTE_W)) begin
                    d.rbyte = shift_r;
                    if ((q.dcnt == DCNT_W'(BYTE_W - 1)) && shift_r[0]) begin
                        d.pre_addr  = shift_r[BYTE_W-1:1];
                        d.pre_valid = 1'b1;
                        d.dcnt      = DCNT_W'(REPLY_W);
                    end
                end else begin
                    d.wdata = shift_w;
                    if (q.dcnt == DCNT_W'(REPLY_W - 1)) wr_en_o = !q.rbyte[0];
                end
            end
            if (q.oe && clk_fall_i) begin
                d.rcnt  = q.rcnt + 1'b1;
                d.reply = q.reply >> 1;
                if (q.rcnt == RCNT_W'(REPLY_W - 1)) d.oe = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_addr_o = q.pre_addr;
    assign wr_addr_o = q.rbyte[BYTE_W-1:1];
    assign wr_data_o = shift_w;
    assign oe_o      = q.oe;
    assign dout_o    = q.oe & q.reply[0];
    assign awake_o   = q.awake;
    assign sel_o     = q.sel;
    assign rd_o      = q.rd;

endmodule

// File: rtl/tws_ctrl_slave.sv
module tws_ctrl_slave
    import tws_pkg::*;
#(
    parameter logic [DEV_AW-1:0] DEV_ADDR  = 6'h2D,
    parameter int unsigned       NUM_REGS  = 128,
    parameter int unsigned       SYNC_STG  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk_i,
    input  logic ser_mode_i,
    input  logic ser_dat_i,
    output logic ser_dat_o,
    output logic ser_dat_oe_o
);

    logic [LINE_N-1:0] pads;
    logic [LINE_N-1:0] line_lvl;
    logic [LINE_N-1:0] line_rise;
    logic [LINE_N-1:0] line_fall;

    logic              mode_lvl;
    logic              ser_fall;
    logic              wr_en;
    logic [REG_AW-1:0] wr_addr;
    logic [WORD_W-1:0] wr_data;
    logic [REG_AW-1:0] rd_addr;
    logic [WORD_W-1:0] rd_data;
    logic              rd_inrange;
    logic              eng_awake;
    logic              eng_sel;
    logic              eng_rd;

    always_comb begin
        pads            = '0;
        pads[LINE_DAT]  = ser_dat_i;
        pads[LINE_MODE] = ser_mode_i;
        pads[LINE_CLK]  = ser_clk_i;
    end

    tws_sync #(
        .WIDTH  (LINE_N),
        .STAGES (SYNC_STG)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i (pads),
        .lvl_o   (line_lvl),
        .rise_o  (line_rise),
        .fall_o  (line_fall)
    );

    assign mode_lvl = line_lvl[LINE_MODE];
    assign ser_fall = line_fall[LINE_CLK];

    tws_engine #(
        .DEV_ADDR (DEV_ADDR)
    ) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .clk_rise_i   (line_rise[LINE_CLK]),
        .clk_fall_i   (ser_fall),
        .mode_lvl_i   (mode_lvl),
        .mode_rise_i  (line_rise[LINE_MODE]),
        .mode_fall_i  (line_fall[LINE_MODE]),
        .dat_i        (line_lvl[LINE_DAT]),
        .rd_data_i    (rd_data),
        .rd_inrange_i (rd_inrange),
        .rd_addr_o    (rd_addr),
        .wr_en_o      (wr_en),
        .wr_addr_o    (wr_addr),
        .wr_data_o    (wr_data),
        .oe_o         (ser_dat_oe_o),
        .dout_o       (ser_dat_o),
        .awake_o      (eng_awake),
        .sel_o        (eng_sel),
        .rd_o         (eng_rd)
    );

    tws_regfile #(
        .NUM_REGS (NUM_REGS),
        .AW       (REG_AW),
        .DW       (WORD_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (wr_en),
        .waddr_i  (wr_addr),
        .wdata_i  (wr_data),
        .raddr_i  (rd_addr),
        .rdata_o  (rd_data),
        .rvalid_o (rd_inrange)
    );

endmodule

// File: rtl/tws_ctrl_slave_chk.sv
module tws_ctrl_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic awake_i,
    input logic sel_i,
    input logic rd_i,
    input logic oe_i,
    input logic dout_i,
    input logic mode_lvl_i,
    input logic ser_fall_i,
    input logic wr_en_i
);

    assert_asleep_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !awake_i |-> (!oe_i && !wr_en_i));

    // also covers R9: an unselected slave never drives
    assert_oe_needs_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        oe_i |-> (sel_i && rd_i));

    assert_write_framing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> (sel_i && !rd_i && mode_lvl_i));

    assert_single_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> !wr_en_i);

    assert_release_on_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_i && !mode_lvl_i) |=> !oe_i);

    assert_dout_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_i && $past(oe_i) && !$past(ser_fall_i)) |-> $stable(dout_i));

endmodule

bind tws_ctrl_slave tws_ctrl_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .awake_i    (eng_awake),
    .sel_i      (eng_sel),
    .rd_i       (eng_rd),
    .oe_i       (ser_dat_oe_o),
    .dout_i     (ser_dat_o),
    .mode_lvl_i (mode_lvl),
    .ser_fall_i (ser_fall),
    .wr_en_i    (wr_en)
);

// File: tb/tb_tws_ctrl_slave.sv
`timescale 1ns/1ps
module tb_tws_ctrl_slave;

    localparam logic [5:0] DEV  = 6'h2D;
    localparam int         NREG = 100;
    localparam int         HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sc = 1'b0;
    logic sm = 1'b1;
    logic sd = 1'b0;
    logic dout, oe;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    tws_ctrl_slave #(.DEV_ADDR(DEV), .NUM_REGS(NREG)) dut (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(sc), .ser_mode_i(sm),
        .ser_dat_i(sd), .ser_dat_o(dout), .ser_dat_oe_o(oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    // ---------------- cycle model: pins -> 3-clock delayed protocol view
    logic [2:0] h1, h2, h3;
    bit m_awake, m_sel, m_rd, m_oe, m_pv;
    int m_acnt, m_dcnt, m_rcnt, m_pa;
    bit m_ab[8];
    bit m_rx[24];
    logic [23:0] m_reply;
    int m_mem[128];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h1 = 0; h2 = 0; h3 = 0;
            m_awake = 0; m_sel = 0; m_rd = 0; m_oe = 0; m_pv = 0;
            m_acnt = 0; m_dcnt = 0; m_rcnt = 0; m_pa = 0; m_reply = 0;
            foreach (m_mem[i]) m_mem[i] = 0;
        end else begin
            bit rise, fall, mrise, mfall, mlvl, dbit;
            rise  = h2[2] && !h3[2];
            fall  = !h2[2] && h3[2];
            mrise = h2[1] && !h3[1];
            mfall = !h2[1] && h3[1];
            mlvl  = h2[1];
            dbit  = h2[0];
            if (!m_awake) begin
                if (rise) m_awake = 1;
            end else if (mfall) begin
                m_acnt = 0; m_sel = 0; m_rd = 0; m_oe = 0;
            end else if (mrise) begin
                bit inv;
                int data;
                m_dcnt = 0; m_rcnt = 0;
                m_oe = m_sel && m_rd;
                inv = !m_pv || (m_pa >= NREG);
                data = inv ? 0 : m_mem[m_pa];
                m_reply = {data[15:0], m_pa[6:0], inv};
            end else if (!mlvl) begin
                if (rise) begin
                    if (m_acnt < 8) begin
                        m_ab[m_acnt] = dbit;
                        m_acnt++;
                        if (m_acnt == 8) begin
                            int dv;
                            dv = 0;
                            for (int k = 2; k < 8; k++) dv += int'(m_ab[k]) << (k - 2);
                            m_sel = (dv == int'(DEV)) && m_ab[1];
                            m_rd  = m_ab[1] && m_ab[0];
                        end
                    end else m_sel = 0;
                end
            end else begin
                if (m_sel && !m_rd && rise && m_dcnt < 24) begin
                    m_rx[m_dcnt] = dbit;
                    m_dcnt++;
                    if (m_dcnt == 8 && m_rx[0]) begin
                        m_pa = 0;
                        for (int k = 1; k < 8; k++) m_pa += int'(m_rx[k]) << (k - 1);
                        m_pv = 1;
                        m_dcnt = 24;
                    end else if (m_dcnt == 24 && !m_rx[0]) begin
                        int a, v;
                        a = 0; v = 0;
                        for (int k = 1; k < 8; k++) a += int'(m_rx[k]) << (k - 1);
                        for (int k = 0; k < 16; k++) v += int'(m_rx[8 + k]) << k;
                        if (a < NREG) m_mem[a] = v;
                    end
                end
                if (m_oe && fall) begin
                    m_rcnt++;
                    if (m_rcnt == 24) m_oe = 0;
                end
            end
            h3 = h2; h2 = h1; h1 = {sc, sm, sd};
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic exp_oe, exp_d;
            exp_oe = m_oe;
            exp_d  = m_oe ? m_reply[m_rcnt] : 1'b0;
            chk((oe === exp_oe) && (dout === exp_d), "R7 per-cycle oe/dout",
                {30'd0, oe, dout}, {30'd0, exp_oe, exp_d});
        end
    end

    // ---------------- bus driver
    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_bit(input logic b);
        sd = b;
        wait_cyc(HALF);
        sc = 1'b1;
        wait_cyc(HALF);
        sc = 1'b0;
    endtask

    task automatic addr_phase(input logic [7:0] byt, input int npulses);
        sm = 1'b0;
        wait_cyc(HALF);
        for (int i = 0; i < npulses; i++) pulse_bit(byt[i % 8]);
        wait_cyc(HALF);
        sm = 1'b1;
        wait_cyc(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) pulse_bit(b[i]);
    endtask

    task automatic do_write(input logic [5:0] dev, input logic [1:0] typ, input int np,
                            input logic [6:0] ra, input logic [15:0] w);
        addr_phase({dev, typ}, np);
        send_byte({ra, 1'b0});
        send_byte(w[7:0]);
        send_byte(w[15:8]);
        wait_cyc(HALF);
    endtask

    task automatic do_preread(input logic [5:0] dev, input logic [1:0] typ, input logic [6:0] ra);
        addr_phase({dev, typ}, 8);
        send_byte({ra, 1'b1});
        wait_cyc(HALF);
    endtask

    task automatic do_read(input logic [5:0] dev, input logic [1:0] typ,
                           output logic [23:0] bits, output int oe_hi, output logic oe_after);
        addr_phase({dev, typ}, 8);
        oe_hi = 0;
        for (int i = 0; i < 24; i++) begin
            wait_cyc(HALF);
            bits[i] = dout;
            oe_hi += int'(oe);
            sc = 1'b1;
            wait_cyc(HALF);
            sc = 1'b0;
        end
        wait_cyc(HALF);
        oe_after = oe;
    endtask

    task automatic read_expect(input string tag, input logic [6:0] ra, input bit inv,
                               input logic [15:0] w);
        logic [23:0] got, exp;
        int hi;
        logic aft;
        do_read(DEV, 2'b11, got, hi, aft);
        exp = {inv ? 16'h0 : w, ra, inv};
        chk(got === exp, tag, {8'd0, got}, {8'd0, exp});
        chk((hi == 24) && (aft == 1'b0), "R7 enable held for 24 bits then released",
            hi, 24);
    endtask

    // ---------------- watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R7 watchdog actual=hung expected=done");
        finish_run();
    end

    // ---------------- stimulus
    initial begin
        logic [23:0] bits;
        int hi;
        logic aft;

        wait_cyc(5);
        chk((oe === 1'b0) && (dout === 1'b0), "R7 reset state", {oe, dout}, 0);
        rst_n = 1'b1;
        wait_cyc(HALF);

        // R2: first pulse wakes only, so this frame loses a bit and selects nothing
        do_write(DEV, 2'b10, 8, 7'd5, 16'h1234);
        chk(oe === 1'b0, "R2 no drive during wake frame", oe, 0);

        // R8: read before any pre-read is invalid with zero data
        read_expect("R8 read without pre-read", 7'd0, 1'b1, 16'h0);

        // R2: the dropped write left register 5 at zero
        do_preread(DEV, 2'b10, 7'd5);
        read_expect("R2 write before wake ignored", 7'd5, 1'b0, 16'h0);

        // R1 / R5: asymmetric word checks bit order
        do_write(DEV, 2'b10, 8, 7'd5, 16'hA5C3);
        read_expect("R1 R5 write then read reg5", 7'd5, 1'b0, 16'hA5C3);

        // R6: latched address holds over a second read
        read_expect("R6 repeated read keeps address", 7'd5, 1'b0, 16'hA5C3);

        // R9: mismatching device address changes nothing and never drives
        do_write(DEV ^ 6'h01, 2'b10, 8, 7'd5, 16'h1111);
        do_preread(DEV ^ 6'h20, 2'b10, 7'd7);
        do_read(DEV ^ 6'h04, 2'b11, bits, hi, aft);
        chk(hi == 0, "R9 no drive on mismatched read", hi, 0);
        read_expect("R9 mismatched write and pre-read ignored", 7'd5, 1'b0, 16'hA5C3);

        // R4: reserved types
        do_write(DEV, 2'b00, 8, 7'd5, 16'h2222);
        do_write(DEV, 2'b01, 8, 7'd5, 16'h3333);
        do_read(DEV, 2'b01, bits, hi, aft);
        chk(hi == 0, "R4 type 01 never drives", hi, 0);
        do_read(DEV, 2'b00, bits, hi, aft);
        chk(hi == 0, "R4 type 00 never drives", hi, 0);
        read_expect("R4 reserved types write nothing", 7'd5, 1'b0, 16'hA5C3);

        // R3: seven and nine pulse frames deselect
        do_write(DEV, 2'b10, 7, 7'd5, 16'h4444);
        do_write(DEV, 2'b10, 9, 7'd5, 16'h5555);
        read_expect("R3 malformed address frames ignored", 7'd5, 1'b0, 16'hA5C3);

        // R5: cut-short data phase commits nothing
        addr_phase({DEV, 2'b10}, 8);
        send_byte({7'd5, 1'b0});
        for (int i = 0; i < 12; i++) pulse_bit(1'b1);
        read_expect("R5 partial write no commit", 7'd5, 1'b0, 16'hA5C3);

        // R6: pre-read of another register, then write it and read again
        do_preread(DEV, 2'b10, 7'd20);
        read_expect("R6 pre-read selects reg20", 7'd20, 1'b0, 16'h0);
        do_write(DEV, 2'b10, 8, 7'd20, 16'h0F1E);
        read_expect("R6 latched address survives a write", 7'd20, 1'b0, 16'h0F1E);

        // R8: last in-range register, then out of range
        do_write(DEV, 2'b10, 8, 7'(NREG - 1), 16'h8001);
        do_preread(DEV, 2'b10, 7'(NREG - 1));
        read_expect("R8 top in-range register", 7'(NREG - 1), 1'b0, 16'h8001);
        do_write(DEV, 2'b10, 8, 7'd110, 16'hBEEF);
        do_preread(DEV, 2'b10, 7'd110);
        read_expect("R8 out-of-range read invalid", 7'd110, 1'b1, 16'h0);

        wait_cyc(20);
        finish_run();
    end

endmodule